// File: doc/BRIEF.md
# Blocking Cache Miss and Write Buffer

This unit handles misses for a cache that stops accepting new work while a miss is outstanding. It owns exactly two storage entries. The miss entry holds a read or write that must travel to memory and may come back as a line fill. The write entry holds stores that skip allocation, and writebacks of evicted lines. While an entry is occupied, the unit raises a stall flag for the cache controller that is specific to that entry. While the entry still waits for the memory bus, it also raises a bus-request line specific to that entry.

The unit offers one pending entry to the memory side at a time. When the bus takes the offered entry, the entry is either retired at once (posted transfers) or marked as in service until a response comes back. For responses that are not line fills, the unit hands the result back to the single waiting requester. For line fills, the tag side handles the requester, so no reply is produced. A thread squash removes the waiting requester of the miss entry and frees that entry if it has not yet been issued.

The cache controller must not allocate into an occupied entry. An allocation attempt of that kind is discarded and flagged on an error output.

Top module: `mwb_buffer`

## Requirements
- R1: After a synchronous active-high reset, both stall flags, both bus-request lines, the offer valid, the reply valid and the error output are all 0.
- R2: A store request (cpu_req_write=1) goes to the write entry when it is uncacheable, when it is posted (no response), or when the WRITE_ALLOCATE parameter is 0. Every other request goes to the miss entry.
- R3: The cycle after an accepted allocation, the stall flag of the chosen entry is 1 and its bus-request line is 1.
- R4: A non-posted request is stored with its address rounded down to a multiple of BLK_BYTES. Posted requests and writebacks keep the full address.
- R5: A cacheable request in the miss entry is a line fill. It is offered with mem_offer_fill=1 and with the bus command FILL_CMD in place of its own command. Uncacheable miss-entry requests and all write-entry requests are offered with their own command and fill=0.
- R6: When the miss entry is occupied and not in service, it is offered (mem_offer_is_wb=0). Otherwise an occupied write entry that is not in service is offered (mem_offer_is_wb=1). Otherwise mem_offer_valid is 0.
- R7: When mem_issue=1 while an offer is valid, the offered entry's bus-request line drops on the next cycle. A posted entry is also freed, which drops its stall flag. Any other entry stays occupied in service and is no longer offered.
- R8: A response (mem_rsp_to_wb: 1 selects the write entry, 0 the miss entry) frees the selected entry on the next cycle. If that entry is not a line fill and still has a waiting requester, reply_valid pulses for one cycle on the next cycle. The reply carries the stored thread and the original command. Its data is mem_rsp_data for a read and 0 for a write. A posted request never has a waiting requester.
- R9: A squash whose thread equals the miss entry's thread removes the waiting requester. If the entry is not in service, it is also freed, which clears its stall flag and bus request. An in-service entry stays until its response, and that response then yields no reply. Squashes that do not match have no effect.
- R10: A writeback allocates the write entry as a posted transfer with command WB_CMD and its compressed flag, which is offered on mem_offer_compressed.
- R11: An allocation into an occupied entry, or a store and a writeback that both target the write entry in the same cycle, pulses alloc_err on the next cycle and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Miss request from the cache controller |
| cpu_req_addr | input | AW | Physical address |
| cpu_req_write | input | 1 | Request is a store |
| cpu_req_uncached | input | 1 | Request is uncacheable |
| cpu_req_posted | input | 1 | Request expects no response |
| cpu_req_thread | input | TW | Issuing thread |
| cpu_req_cmd | input | CW | Original command |
| cpu_req_data | input | DW | Store data |
| wbk_valid | input | 1 | Writeback of an evicted line |
| wbk_addr | input | AW | Writeback address |
| wbk_thread | input | TW | Thread charged for the writeback |
| wbk_compressed | input | 1 | Writeback data is compressed |
| wbk_data | input | DW | Writeback data |
| stall_miss | output | 1 | Miss entry occupied |
| stall_wb | output | 1 | Write entry occupied |
| mem_want_miss | output | 1 | Miss entry requests the bus |
| mem_want_wb | output | 1 | Write entry requests the bus |
| mem_offer_valid | output | 1 | An entry is offered to memory |
| mem_offer_is_wb | output | 1 | Offered entry is the write entry |
| mem_offer_addr | output | AW | Offered address |
| mem_offer_cmd | output | CW | Bus command, with fill substitution applied |
| mem_offer_fill | output | 1 | Offered entry is a line fill |
| mem_offer_posted | output | 1 | Offered entry expects no response |
| mem_offer_compressed | output | 1 | Offered writeback is compressed |
| mem_offer_thread | output | TW | Offered entry's thread |
| mem_offer_data | output | DW | Offered entry's data |
| mem_issue | input | 1 | Bus takes the offered entry |
| mem_rsp_valid | input | 1 | Response from memory |
| mem_rsp_to_wb | input | 1 | Response targets the write entry |
| mem_rsp_data | input | DW | Response data |
| squash_valid | input | 1 | Squash request |
| squash_thread | input | TW | Thread being squashed |
| reply_valid | output | 1 | Reply to the waiting requester |
| reply_thread | output | TW | Reply thread |
| reply_cmd | output | CW | Restored original command |
| reply_data | output | DW | Reply data |
| alloc_err | output | 1 | Illegal allocation seen last cycle |

## Verification
The assertions rely on the controller following the protocol. It allocates only into free entries, except on purpose, in which case the attempt must have no effect. It issues only while an offer is valid, and it sends responses only to entries that are in service. Under these conditions, a rise of a stall flag, a reply or an error can always be traced to an input of the previous cycle. The random stimulus respects these limits. It routes each request before it drives it, and it mostly turns a request for an occupied entry into an idle cycle. Only a small fraction of such requests is driven anyway, to check that the error path leaves the entries unchanged. Responses are chosen only among entries that are in service. Directed cases cover the same-cycle store and writeback conflict and squashes that hit an entry before and after issue.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
  // Entry indices; the miss entry wins arbitration, so its index is lower.
  localparam int unsigned SLOT_MISS = 0;
  localparam int unsigned SLOT_WB   = 1;
  localparam int unsigned NSLOT     = 2;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_MISS = 2'd1,
    DEST_WB   = 2'd2
  } dest_e;
endpackage

// File: rtl/mwb_route.sv
`timescale 1ns/1ps
module mwb_route #(
  parameter bit WRITE_ALLOCATE = 1'b1
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_uncached,
  input  logic          req_posted,
  output mwb_pkg::dest_e dest,
  output logic          fill,
  output logic          has_target
);
  import mwb_pkg::*;

  logic bypass;
  assign bypass = req_write && (req_uncached || req_posted || !WRITE_ALLOCATE);

  always_comb begin
    if (!req_valid)  dest = DEST_NONE;
    else if (bypass) dest = DEST_WB;
    else             dest = DEST_MISS;
  end

  // Only a cacheable request in the miss entry becomes a line fill.
  assign fill       = req_valid && !bypass && !req_uncached;
  assign has_target = !req_posted;
endmodule

// File: rtl/mwb_slot.sv
`timescale 1ns/1ps
module mwb_slot #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          alloc_posted,
  input  logic          alloc_target,
  input  logic [PW-1:0] alloc_pl,
  input  logic          issue,
  input  logic          rsp,
  input  logic          squash,
  output logic          valid,
  output logic          in_svc,
  output logic          has_target,
  output logic          posted,
  output logic [PW-1:0] pl
);
  logic take;
  assign take = alloc && !valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid      <= 1'b0;
      in_svc     <= 1'b0;
      has_target <= 1'b0;
      posted     <= 1'b0;
    end else if (rsp && valid) begin
      valid      <= 1'b0;
      in_svc     <= 1'b0;
      has_target <= 1'b0;
    end else if (issue && valid && !in_svc) begin
      if (posted) begin
        valid      <= 1'b0;
        has_target <= 1'b0;
      end else begin
        in_svc <= 1'b1;
      end
    end else if (squash && valid) begin
      has_target <= 1'b0;
      if (!in_svc) valid <= 1'b0;
    end else if (take) begin
      valid      <= 1'b1;
      in_svc     <= 1'b0;
      has_target <= alloc_target;
      posted     <= alloc_posted;
    end
  end

  // Payload has no reset so it maps onto plain storage.
  always_ff @(posedge clk) begin
    if (take) pl <= alloc_pl;
  end
endmodule

// File: rtl/mwb_pick.sv
`timescale 1ns/1ps
module mwb_pick #(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] sel
);
  // Fixed priority: lowest index pending wins.
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) sel = IW'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/mwb_buffer.sv
`timescale 1ns/1ps
module mwb_buffer #(
  parameter int unsigned AW             = 32,
  parameter int unsigned DW             = 32,
  parameter int unsigned CW             = 4,
  parameter int unsigned TW             = 2,
  parameter int unsigned BLK_BYTES      = 32,
  parameter bit          WRITE_ALLOCATE = 1'b1,
  parameter logic [CW-1:0] FILL_CMD     = 4'hA,
  parameter logic [CW-1:0] WB_CMD       = 4'hB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req_valid,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic          cpu_req_write,
  input  logic          cpu_req_uncached,
  input  logic          cpu_req_posted,
  input  logic [TW-1:0] cpu_req_thread,
  input  logic [CW-1:0] cpu_req_cmd,
  input  logic [DW-1:0] cpu_req_data,
  input  logic          wbk_valid,
  input  logic [AW-1:0] wbk_addr,
  input  logic [TW-1:0] wbk_thread,
  input  logic          wbk_compressed,
  input  logic [DW-1:0] wbk_data,
  output logic          stall_miss,
  output logic          stall_wb,
  output logic          mem_want_miss,
  output logic          mem_want_wb,
  output logic          mem_offer_valid,
  output logic          mem_offer_is_wb,
  output logic [AW-1:0] mem_offer_addr,
  output logic [CW-1:0] mem_offer_cmd,
  output logic          mem_offer_fill,
  output logic          mem_offer_posted,
  output logic          mem_offer_compressed,
  output logic [TW-1:0] mem_offer_thread,
  output logic [DW-1:0] mem_offer_data,
  input  logic          mem_issue,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_to_wb,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          squash_valid,
  input  logic [TW-1:0] squash_thread,
  output logic          reply_valid,
  output logic [TW-1:0] reply_thread,
  output logic [CW-1:0] reply_cmd,
  output logic [DW-1:0] reply_data,
  output logic          alloc_err
);
  import mwb_pkg::*;

  // Payload layout: {write, fill, compressed, thread, addr, cmd, data}
  localparam int unsigned C_LSB   = DW;
  localparam int unsigned A_LSB   = C_LSB + CW;
  localparam int unsigned T_LSB   = A_LSB + AW;
  localparam int unsigned CMP_BIT = T_LSB + TW;
  localparam int unsigned FIL_BIT = CMP_BIT + 1;
  localparam int unsigned WR_BIT  = FIL_BIT + 1;
  localparam int unsigned PW      = WR_BIT + 1;
  localparam logic [AW-1:0] OFF_MASK = AW'(BLK_BYTES - 1);

  // ---------------- routing of new requests ----------------
  dest_e          cpu_dest;
  logic           cpu_fill, cpu_target;
  logic [AW-1:0]  cpu_addr_use;
  logic [PW-1:0]  cpu_pl, wbk_pl;

  mwb_route #(.WRITE_ALLOCATE(WRITE_ALLOCATE)) route_i (
    .req_valid    (cpu_req_valid),
    .req_write    (cpu_req_write),
    .req_uncached (cpu_req_uncached),
    .req_posted   (cpu_req_posted),
    .dest         (cpu_dest),
    .fill         (cpu_fill),
    .has_target   (cpu_target)
  );

  assign cpu_addr_use = cpu_req_posted ? cpu_req_addr : (cpu_req_addr & ~OFF_MASK);
  assign cpu_pl = {cpu_req_write, cpu_fill, 1'b0, cpu_req_thread,
                   cpu_addr_use, cpu_req_cmd, cpu_req_data};
  assign wbk_pl = {1'b1, 1'b0, wbk_compressed, wbk_thread,
                   wbk_addr, WB_CMD, wbk_data};

  // ---------------- entry storage ----------------
  logic [NSLOT-1:0] s_alloc, s_posted_in, s_target_in, s_issue, s_rsp, s_squash;
  logic [NSLOT-1:0] s_valid, s_in_svc, s_target, s_posted, s_pend;
  logic [PW-1:0]    s_pl_in [NSLOT];
  logic [PW-1:0]    s_pl    [NSLOT];

  logic cpu_to_miss, cpu_to_wb, wb_clash;
  assign cpu_to_miss = (cpu_dest == DEST_MISS);
  assign cpu_to_wb   = (cpu_dest == DEST_WB);
  assign wb_clash    = cpu_to_wb && wbk_valid;

  assign s_alloc[SLOT_MISS]     = cpu_to_miss;
  assign s_posted_in[SLOT_MISS] = cpu_req_posted;
  assign s_target_in[SLOT_MISS] = cpu_target;
  assign s_pl_in[SLOT_MISS]     = cpu_pl;

  assign s_alloc[SLOT_WB]       = (cpu_to_wb || wbk_valid) && !wb_clash;
  assign s_posted_in[SLOT_WB]   = wbk_valid ? 1'b1 : cpu_req_posted;
  assign s_target_in[SLOT_WB]   = wbk_valid ? 1'b0 : cpu_target;
  assign s_pl_in[SLOT_WB]       = wbk_valid ? wbk_pl : cpu_pl;

  // ---------------- offer arbitration ----------------
  logic                     offer_any;
  logic [$clog2(NSLOT)-1:0] offer_sel;

  mwb_pick #(.N(NSLOT), .IW($clog2(NSLOT))) pick_i (
    .pend (s_pend),
    .any  (offer_any),
    .sel  (offer_sel)
  );

  logic squash_hit;
  assign squash_hit = squash_valid &&
                      (s_pl[SLOT_MISS][T_LSB +: TW] == squash_thread);

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign s_issue[g]  = mem_issue && offer_any && (offer_sel == g);
      assign s_rsp[g]    = mem_rsp_valid && (mem_rsp_to_wb == (g == SLOT_WB));
      assign s_squash[g] = (g == SLOT_MISS) ? squash_hit : 1'b0;
      assign s_pend[g]   = s_valid[g] && !s_in_svc[g];

      mwb_slot #(.PW(PW)) slot_i (
        .clk          (clk),
        .rst          (rst),
        .alloc        (s_alloc[g]),
        .alloc_posted (s_posted_in[g]),
        .alloc_target (s_target_in[g]),
        .alloc_pl     (s_pl_in[g]),
        .issue        (s_issue[g]),
        .rsp          (s_rsp[g]),
        .squash       (s_squash[g]),
        .valid        (s_valid[g]),
        .in_svc       (s_in_svc[g]),
        .has_target   (s_target[g]),
        .posted       (s_posted[g]),
        .pl           (s_pl[g])
      );
    end
  endgenerate

  // ---------------- cache and bus side flags ----------------
  assign stall_miss    = s_valid[SLOT_MISS];
  assign stall_wb      = s_valid[SLOT_WB];
  assign mem_want_miss = s_pend[SLOT_MISS];
  assign mem_want_wb   = s_pend[SLOT_WB];

  logic [PW-1:0] opl;
  assign opl = s_pl[offer_sel];

  assign mem_offer_valid      = offer_any;
  assign mem_offer_is_wb      = (offer_sel == SLOT_WB);
  assign mem_offer_addr       = opl[A_LSB +: AW];
  assign mem_offer_fill       = opl[FIL_BIT];
  assign mem_offer_cmd        = opl[FIL_BIT] ? FILL_CMD : opl[C_LSB +: CW];
  assign mem_offer_posted     = s_posted[offer_sel];
  assign mem_offer_compressed = opl[CMP_BIT];
  assign mem_offer_thread     = opl[T_LSB +: TW];
  assign mem_offer_data       = opl[DW-1:0];

  // ---------------- reply and error registers ----------------
  logic [PW-1:0] rpl;
  logic          rsp_idx;
  logic          err_d;
  assign rsp_idx = mem_rsp_to_wb;
  assign rpl     = s_pl[rsp_idx];
  assign err_d   = (cpu_to_miss && s_valid[SLOT_MISS]) ||
                   ((cpu_to_wb || wbk_valid) && s_valid[SLOT_WB]) ||
                   wb_clash;

  always_ff @(posedge clk) begin
    if (rst) begin
      reply_valid  <= 1'b0;
      reply_thread <= '0;
      reply_cmd    <= '0;
      reply_data   <= '0;
      alloc_err    <= 1'b0;
    end else begin
      reply_valid  <= mem_rsp_valid && s_valid[rsp_idx] &&
                      s_target[rsp_idx] && !rpl[FIL_BIT];
      reply_thread <= rpl[T_LSB +: TW];
      reply_cmd    <= rpl[C_LSB +: CW];
      reply_data   <= rpl[WR_BIT] ? '0 : mem_rsp_data;
      alloc_err    <= err_d;
    end
  end
endmodule

// File: rtl/mwb_checker.sv
`timescale 1ns/1ps
module mwb_checker (
  input logic clk,
  input logic rst,
  input logic cpu_req_valid,
  input logic wbk_valid,
  input logic stall_miss,
  input logic stall_wb,
  input logic mem_want_miss,
  input logic mem_want_wb,
  input logic mem_offer_valid,
  input logic mem_offer_is_wb,
  input logic mem_offer_posted,
  input logic mem_issue,
  input logic mem_rsp_valid,
  input logic reply_valid,
  input logic alloc_err
);
  assert_miss_alloc_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_miss) |-> $past(cpu_req_valid));

  assert_wb_alloc_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_wb) |-> $past(cpu_req_valid || wbk_valid));

  assert_miss_first_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_offer_valid && mem_offer_is_wb) |-> !mem_want_miss);

  assert_want_held_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_want_miss |-> stall_miss) and (mem_want_wb |-> stall_wb));

  assert_posted_miss_free_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_issue && mem_offer_valid && mem_offer_posted && !mem_offer_is_wb)
      |=> !stall_miss);

  assert_posted_wb_free_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_issue && mem_offer_valid && mem_offer_posted && mem_offer_is_wb)
      |=> !stall_wb);

  assert_reply_cause_R8: assert property (@(posedge clk) disable iff (rst)
    reply_valid |-> $past(mem_rsp_valid));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (rst)
    alloc_err |-> $past(cpu_req_valid || wbk_valid));
endmodule

bind mwb_buffer mwb_checker chk_i (
  .clk              (clk),
  .rst              (rst),
  .cpu_req_valid    (cpu_req_valid),
  .wbk_valid        (wbk_valid),
  .stall_miss       (stall_miss),
  .stall_wb         (stall_wb),
  .mem_want_miss    (mem_want_miss),
  .mem_want_wb      (mem_want_wb),
  .mem_offer_valid  (mem_offer_valid),
  .mem_offer_is_wb  (mem_offer_is_wb),
  .mem_offer_posted (mem_offer_posted),
  .mem_issue        (mem_issue),
  .mem_rsp_valid    (mem_rsp_valid),
  .reply_valid      (reply_valid),
  .alloc_err        (alloc_err)
);

// File: tb/mwb_buffer_tb_top.sv
`timescale 1ns/1ps
module mwb_buffer_tb_top;
  localparam bit        WA    = 1'b1;
  localparam logic [3:0] FCMD = 4'hA;
  localparam logic [3:0] WCMD = 4'hB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic        cpu_req_valid, cpu_req_write, cpu_req_uncached, cpu_req_posted;
  logic [31:0] cpu_req_addr, cpu_req_data;
  logic [1:0]  cpu_req_thread;
  logic [3:0]  cpu_req_cmd;
  logic        wbk_valid, wbk_compressed;
  logic [31:0] wbk_addr, wbk_data;
  logic [1:0]  wbk_thread;
  logic        stall_miss, stall_wb, mem_want_miss, mem_want_wb;
  logic        mem_offer_valid, mem_offer_is_wb, mem_offer_fill, mem_offer_posted, mem_offer_compressed;
  logic [31:0] mem_offer_addr, mem_offer_data;
  logic [3:0]  mem_offer_cmd;
  logic [1:0]  mem_offer_thread;
  logic        mem_issue, mem_rsp_valid, mem_rsp_to_wb;
  logic [31:0] mem_rsp_data;
  logic        squash_valid;
  logic [1:0]  squash_thread;
  logic        reply_valid, alloc_err;
  logic [1:0]  reply_thread;
  logic [3:0]  reply_cmd;
  logic [31:0] reply_data;

  mwb_buffer #(.AW(32), .DW(32), .CW(4), .TW(2), .BLK_BYTES(32),
               .WRITE_ALLOCATE(WA), .FILL_CMD(FCMD), .WB_CMD(WCMD)) dut_i (.*);

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // Reference state: index 0 = miss entry, 1 = write entry
  bit          mv[2], ms[2], mt[2], mfill[2], mpost[2], mcomp[2], mwr[2];
  logic [31:0] maddr[2], mdata[2];
  logic [3:0]  mcmd[2];
  logic [1:0]  mthr[2];
  bit          erv, eerr;
  logic [1:0]  erthr;
  logic [3:0]  ercmd;
  logic [31:0] erdata;

  task automatic chk(input string rq, input string nm, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, nm, act, exp);
    end
  endtask

  function automatic bit to_wb(input bit wr, input bit unc, input bit post);
    return wr && (unc || post || !WA);
  endfunction

  function automatic int offer_idx();
    if (mv[0] && !ms[0]) return 0;
    if (mv[1] && !ms[1]) return 1;
    return -1;
  endfunction

  task automatic clr();
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_uncached = 0; cpu_req_posted = 0;
    cpu_req_addr = 0; cpu_req_data = 0; cpu_req_thread = 0; cpu_req_cmd = 0;
    wbk_valid = 0; wbk_compressed = 0; wbk_addr = 0; wbk_data = 0; wbk_thread = 0;
    mem_issue = 0; mem_rsp_valid = 0; mem_rsp_to_wb = 0; mem_rsp_data = 0;
    squash_valid = 0; squash_thread = 0;
  endtask

  task automatic check_all();
    int oi;
    oi = offer_idx();
    chk("R2 R3 R7 R9", "stall_miss", stall_miss, mv[0]);
    chk("R2 R3 R7", "stall_wb", stall_wb, mv[1]);
    chk("R3 R7 R9", "want_miss", mem_want_miss, mv[0] && !ms[0]);
    chk("R3 R7", "want_wb", mem_want_wb, mv[1] && !ms[1]);
    chk("R6", "offer_valid", mem_offer_valid, oi >= 0);
    if (oi >= 0) begin
      chk("R6", "offer_is_wb", mem_offer_is_wb, oi == 1);
      chk("R4", "offer_addr", mem_offer_addr, maddr[oi]);
      chk("R5", "offer_fill", mem_offer_fill, mfill[oi]);
      chk("R5 R10", "offer_cmd", mem_offer_cmd, mfill[oi] ? FCMD : mcmd[oi]);
      chk("R7", "offer_posted", mem_offer_posted, mpost[oi]);
      chk("R10", "offer_compressed", mem_offer_compressed, mcomp[oi]);
      chk("R10", "offer_thread", mem_offer_thread, mthr[oi]);
      chk("R11", "offer_data", mem_offer_data, mdata[oi]);
    end
    chk("R8 R9", "reply_valid", reply_valid, erv);
    if (erv) begin
      chk("R8", "reply_thread", reply_thread, erthr);
      chk("R8", "reply_cmd", reply_cmd, ercmd);
      chk("R8", "reply_data", reply_data, erdata);
    end
    chk("R11", "alloc_err", alloc_err, eerr);
  endtask

  // Inputs are already driven (after a falling edge); clock them in and check.
  task automatic tick();
    @(posedge clk);
    #5;
    check_all();
    @(negedge clk);
    clr();
    erv = 0; eerr = 0;
  endtask

  task automatic put(input int i, input bit post, input bit tgt, input bit fill, input bit comp,
                     input bit wr, input logic [31:0] a, input logic [3:0] c,
                     input logic [1:0] t, input logic [31:0] d);
    mv[i] = 1; ms[i] = 0; mt[i] = tgt; mpost[i] = post; mfill[i] = fill; mcomp[i] = comp;
    mwr[i] = wr; maddr[i] = a; mcmd[i] = c; mthr[i] = t; mdata[i] = d;
  endtask

  task automatic op_req(input logic [31:0] a, input bit wr, input bit unc, input bit post,
                        input logic [1:0] t, input logic [3:0] c, input logic [31:0] d);
    int i;
    cpu_req_valid = 1; cpu_req_addr = a; cpu_req_write = wr; cpu_req_uncached = unc;
    cpu_req_posted = post; cpu_req_thread = t; cpu_req_cmd = c; cpu_req_data = d;
    i = to_wb(wr, unc, post) ? 1 : 0;
    if (mv[i]) eerr = 1;
    else put(i, post, !post, (i == 0) && !unc, 0, wr, post ? a : (a & ~32'd31), c, t, d);
    tick();
  endtask

  task automatic op_wbk(input logic [31:0] a, input logic [1:0] t, input bit comp, input logic [31:0] d);
    wbk_valid = 1; wbk_addr = a; wbk_thread = t; wbk_compressed = comp; wbk_data = d;
    if (mv[1]) eerr = 1;
    else put(1, 1, 0, 0, comp, 1, a, WCMD, t, d);
    tick();
  endtask

  task automatic op_issue();
    int oi;
    mem_issue = 1;
    oi = offer_idx();
    if (oi >= 0) begin
      if (mpost[oi]) begin mv[oi] = 0; mt[oi] = 0; end
      else ms[oi] = 1;
    end
    tick();
  endtask

  task automatic op_rsp(input int i, input logic [31:0] d);
    mem_rsp_valid = 1; mem_rsp_to_wb = (i == 1); mem_rsp_data = d;
    if (mv[i]) begin
      if (!mfill[i] && mt[i]) begin
        erv = 1; erthr = mthr[i]; ercmd = mcmd[i]; erdata = mwr[i] ? 32'd0 : d;
      end
      mv[i] = 0; ms[i] = 0; mt[i] = 0;
    end
    tick();
  endtask

  task automatic op_squash(input logic [1:0] t);
    squash_valid = 1; squash_thread = t;
    if (mv[0] && mthr[0] == t) begin
      mt[0] = 0;
      if (!ms[0]) mv[0] = 0;
    end
    tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr();
    for (int i = 0; i < 2; i++) begin mv[i] = 0; ms[i] = 0; mt[i] = 0; end
    erv = 0; eerr = 0;
    void'($urandom(32'd1357));
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "reset stall_miss", stall_miss, 0);
    chk("R1", "reset stall_wb", stall_wb, 0);
    chk("R1", "reset want", {mem_want_miss, mem_want_wb}, 0);
    chk("R1", "reset offer", mem_offer_valid, 0);
    chk("R1", "reset reply/err", {reply_valid, alloc_err}, 0);

    // R4 R5: cacheable read is aligned, marked fill, command substituted; fill reply suppressed (R8)
    op_req(32'h1234_5677, 0, 0, 0, 2'd1, 4'h2, 32'h0);
    op_issue();
    op_rsp(0, 32'hDEAD_BEEF);
    // R8: uncacheable read returns data with original command
    op_req(32'h0000_100F, 0, 1, 0, 2'd2, 4'h3, 32'h0);
    op_issue();
    op_rsp(0, 32'hCAFE_0001);
    // R2 R6: cacheable store to miss entry, uncached store to write entry, miss offered first
    op_req(32'h0000_2004, 1, 0, 0, 2'd0, 4'h5, 32'h1111_2222);
    op_req(32'h0000_3008, 1, 1, 0, 2'd3, 4'h6, 32'h3333_4444);
    op_issue();
    op_issue();
    op_rsp(1, 32'h5555_6666);   // write reply data 0
    op_rsp(0, 32'h0);
    // R4 R7: posted store keeps full address and frees on issue
    op_req(32'h0000_4013, 1, 0, 1, 2'd1, 4'h7, 32'h7777_8888);
    op_issue();
    // R10 R11: compressed writeback, then second writeback rejected
    op_wbk(32'h0000_5005, 2'd2, 1, 32'h9999_AAAA);
    op_wbk(32'h0000_6000, 2'd3, 0, 32'h0);
    op_issue();
    // R11: store and writeback clash on the write entry
    cpu_req_valid = 1; cpu_req_write = 1; cpu_req_uncached = 1; cpu_req_addr = 32'h700;
    wbk_valid = 1; wbk_addr = 32'h800;
    eerr = 1;
    tick();
    // R11: miss entry occupied, second miss rejected and entry unchanged
    op_req(32'h0000_9000, 0, 0, 0, 2'd2, 4'h1, 32'h0);
    op_req(32'h0000_A000, 0, 1, 0, 2'd0, 4'h4, 32'h0);
    // R9: non-matching squash ignored, matching squash frees before issue
    op_squash(2'd1);
    op_squash(2'd2);
    // R9: squash after issue keeps entry, response gives no reply
    op_req(32'h0000_B010, 0, 1, 0, 2'd3, 4'h3, 32'h0);
    op_issue();
    op_squash(2'd3);
    op_rsp(0, 32'h1234_0000);

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom % 7;
      if (k <= 1) begin
        bit wr, unc, post;
        int i;
        wr = $urandom % 2; unc = ($urandom % 4) == 0; post = ($urandom % 4) == 0;
        i = to_wb(wr, unc, post) ? 1 : 0;
        if (!mv[i] || ($urandom % 8) == 0)
          op_req($urandom, wr, unc, post, 2'($urandom), 4'($urandom), $urandom);
        else tick();
      end else if (k == 2) begin
        if (!mv[1] || ($urandom % 8) == 0)
          op_wbk($urandom, 2'($urandom), 1'($urandom), $urandom);
        else tick();
      end else if (k <= 4) begin
        op_issue();
      end else if (k == 5) begin
        if (ms[0] && (!ms[1] || ($urandom % 2) == 0)) op_rsp(0, $urandom);
        else if (ms[1]) op_rsp(1, $urandom);
        else tick();
      end else begin
        op_squash(2'($urandom));
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule